// File: doc/BRIEF.md
# Four-Function Unsigned ALU

This block combines two unsigned operands under a two-bit operation code. It adds them, subtracts the second from the first, or forms their bitwise AND or bitwise OR. Besides the data result it reports a carry/borrow flag and a two's-complement overflow flag. Both flags are meaningful only for the two arithmetic operations. For AND and OR they are held at zero.

For add and subtract, both operands are widened by one leading zero bit. The top bit of the widened result is the carry (add) or the borrow (subtract). A parameter selects between two adder structures: one shared adder that inverts the second operand for subtraction, or separate add and subtract paths. A second parameter places a register stage on the outputs, which is cleared by an active-low reset. With the default setting the outputs follow the inputs after one clock edge.

Top module: `alu4_core`

## Requirements
- R1: With op_i = 2'b00 (add), res_o is (a_i + b_i) mod 256 and cy_o is bit 8 of the 9-bit zero-extended sum.
- R2: With op_i = 2'b01 (subtract), res_o is (a_i − b_i) mod 256 and cy_o is 1 exactly when a_i < b_i as unsigned values.
- R3: With op_i = 2'b10 (AND), res_o is the bitwise AND of a_i and b_i.
- R4: With op_i = 2'b11 (OR), res_o is the bitwise OR of a_i and b_i.
- R5: For the AND and OR operations, cy_o and ov_o are both 0, whatever the operand values.
- R6: For add, ov_o is 1 exactly when bit 7 of a_i equals bit 7 of b_i and bit 7 of res_o differs from it (for example 0x7F + 0x01 gives 0x80 with ov_o = 1 and cy_o = 0, and 0xFF + 0x01 gives 0x00 with cy_o = 1 and ov_o = 0).
- R7: For subtract, ov_o is 1 exactly when bit 7 of a_i differs from bit 7 of b_i and bit 7 of res_o differs from bit 7 of a_i.
- R8: With OUT_REG = 1 (default), res_o, cy_o and ov_o present the result of the inputs sampled at the previous rising clock edge. While rst_n is low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset that clears the output register |
| op_i | input | 2 | Operation code: 00 add, 01 subtract, 10 AND, 11 OR |
| a_i | input | 8 | First operand, unsigned |
| b_i | input | 8 | Second operand, unsigned |
| res_o | output | 8 | Operation result |
| cy_o | output | 1 | Carry on add, borrow on subtract, 0 otherwise |
| ov_o | output | 1 | Signed overflow on add or subtract, 0 otherwise |

## Verification
The hardest cases to reach are those where the signed overflow flag and the unsigned carry/borrow flag disagree. Examples are a subtract that borrows without overflowing (0x00 − 0x01) and one that overflows without borrowing (0x80 − 0x01). A mutation that swaps or merges the two flags goes unnoticed on ordinary operands. The stimulus therefore targets the sign-boundary values 0x7F, 0x80, 0x00 and 0xFF for both arithmetic codes. It also drives AND and OR with operands that would produce a carry and an overflow if added, which shows that both flags stay low.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_AND = 2'b10,
      OP_OR  = 2'b11
   } alu_op_e;
endpackage

// File: rtl/alu4_arith.sv
module alu4_arith #(
   parameter int W          = 8,
   parameter bit SHARED_ADD = 1'b1
) (
   input  logic         sub_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o,
   output logic         cy_o,
   output logic         ov_o
);
   localparam int WX  = W + 1;
   localparam int MSB = W - 1;

   logic [WX-1:0] wide;

   generate
      if (SHARED_ADD) begin : g_shared
         logic [WX-1:0] b_eff;
         always_comb begin
            b_eff = sub_i ? ~{1'b0, b_i} : {1'b0, b_i};
            wide  = {1'b0, a_i} + b_eff + {{W{1'b0}}, sub_i};
         end
      end else begin : g_split
         logic [WX-1:0] add_w, sub_w;
         always_comb begin
            add_w = {1'b0, a_i} + {1'b0, b_i};
            sub_w = {1'b0, a_i} - {1'b0, b_i};
            wide  = sub_i ? sub_w : add_w;
         end
      end
   endgenerate

   always_comb begin
      sum_o = wide[W-1:0];
      cy_o  = wide[W];
      if (sub_i)
         ov_o = (a_i[MSB] != b_i[MSB]) && (wide[MSB] != a_i[MSB]);
      else
         ov_o = (a_i[MSB] == b_i[MSB]) && (wide[MSB] != a_i[MSB]);
   end
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic #(
   parameter int W = 8
) (
   input  logic         or_sel_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] res_o
);
   for (genvar g = 0; g < W; g++) begin : g_bit
      assign res_o[g] = or_sel_i ? (a_i[g] | b_i[g]) : (a_i[g] & b_i[g]);
   end
endmodule

// File: rtl/alu4_core.sv
module alu4_core
   import alu4_pkg::*;
#(
   parameter int W          = 8,
   parameter bit SHARED_ADD = 1'b1,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] res_o,
   output logic         cy_o,
   output logic         ov_o
);
   localparam int MSB = W - 1;

   if (W < 2) begin : g_bad_width
      $error("alu4_core: W must be at least 2");
   end

   alu_op_e       op;
   logic [W-1:0]  ar_sum, lg_res, res_c;
   logic          ar_cy, ar_ov, cy_c, ov_c;

   assign op = alu_op_e'(op_i);

   alu4_arith #(.W(W), .SHARED_ADD(SHARED_ADD)) u_arith (
      .sub_i (op == OP_SUB),
      .a_i   (a_i),
      .b_i   (b_i),
      .sum_o (ar_sum),
      .cy_o  (ar_cy),
      .ov_o  (ar_ov)
   );

   alu4_logic #(.W(W)) u_logic (
      .or_sel_i (op == OP_OR),
      .a_i      (a_i),
      .b_i      (b_i),
      .res_o    (lg_res)
   );

   always_comb begin
      if (op_i[1]) begin
         res_c = lg_res;
         cy_c  = 1'b0;
         ov_c  = 1'b0;
      end else begin
         res_c = ar_sum;
         cy_c  = ar_cy;
         ov_c  = ar_ov;
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_o <= '0;
            cy_o  <= 1'b0;
            ov_o  <= 1'b0;
         end else begin
            res_o <= res_c;
            cy_o  <= cy_c;
            ov_o  <= ov_c;
         end
      end

      // R8: outputs carry the previous cycle's combinational result
      a_r8_reg_stage: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (res_o == $past(res_c)) && (cy_o == $past(cy_c)) && (ov_o == $past(ov_c)));
   end else begin : g_comb
      always_comb begin
         res_o = res_c;
         cy_o  = cy_c;
         ov_o  = ov_c;
      end
   end

   // R1: add matches the widened sum
   a_r1_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'b00) |-> ({cy_c, res_c} == ({1'b0, a_i} + {1'b0, b_i})));
   // R2: borrow reflects the unsigned comparison
   a_r2_borrow: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'b01) |-> (cy_c == (a_i < b_i)));
   // R3: AND result never sets a bit absent from either operand
   a_r3_and_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'b10) |-> (((res_c & ~a_i) | (res_c & ~b_i)) == '0));
   // R4: OR result covers both operands
   a_r4_or_cover: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'b11) |-> (((a_i | b_i) & ~res_c) == '0));
   // R5: logic operations keep both flags low
   a_r5_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
      op_i[1] |-> (!cy_c && !ov_c));
   // R6: an add of operands with differing signs cannot overflow
   a_r6_add_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i == 2'b00) && (a_i[MSB] != b_i[MSB])) |-> !ov_c);
   // R7: a subtract of operands with equal signs cannot overflow
   a_r7_sub_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i == 2'b01) && (a_i[MSB] == b_i[MSB])) |-> !ov_c);
endmodule

// File: tb/test_alu4_core.sv
module test_alu4_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] op = 2'b00;
   logic [7:0] a = 8'h00, b = 8'h00;
   logic [7:0] res;
   logic       cy, ov;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   alu4_core i_alu4_core (
      .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
      .res_o(res), .cy_o(cy), .ov_o(ov)
   );

   task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {cy,ov,res} actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [9:0] model(input logic [1:0] o, input logic [7:0] x, input logic [7:0] y);
      int s;
      logic [7:0] r;
      logic c, v;
      c = 1'b0; v = 1'b0;
      case (o)
         2'b00: begin s = int'(x) + int'(y); r = s[7:0]; c = (s > 255);
                v = (x[7] == y[7]) && (r[7] != x[7]); end
         2'b01: begin s = int'(x) - int'(y); r = s[7:0]; c = (x < y);
                v = (x[7] != y[7]) && (r[7] != x[7]); end
         2'b10: r = x & y;
         default: r = x | y;
      endcase
      return {c, v, r};
   endfunction

   task automatic apply(input string req, input logic [1:0] o, input logic [7:0] x, input logic [7:0] y);
      @(negedge clk);
      op = o; a = x; b = y;
      @(negedge clk);
      check(req, {cy, ov, res}, model(o, x, y));
   endtask

   task automatic t_reset();
      check("R8 reset", {cy, ov, res}, 10'h000);
   endtask

   task automatic t_add();
      apply("R1 add small", 2'b00, 8'h12, 8'h34);
      apply("R1 add carry 0xFF+0x01", 2'b00, 8'hFF, 8'h01);
      check("R1 explicit 0xFF+0x01", {cy, ov, res}, 10'h200);
      apply("R1 add carry+ovf", 2'b00, 8'h80, 8'h80);
      check("R6 explicit 0x80+0x80", {cy, ov, res}, 10'h300);
   endtask

   task automatic t_sub();
      apply("R2 sub no borrow", 2'b01, 8'h50, 8'h20);
      apply("R2 sub borrow", 2'b01, 8'h00, 8'h01);
      check("R2 explicit 0x00-0x01", {cy, ov, res}, 10'h2FF);
      apply("R2 sub equal", 2'b01, 8'hA5, 8'hA5);
   endtask

   task automatic t_logic();
      apply("R3 and", 2'b10, 8'hF0, 8'h3C);
      apply("R3 and zero", 2'b10, 8'hAA, 8'h55);
      apply("R4 or", 2'b11, 8'hA0, 8'h05);
      apply("R5 and flags 0xFF&0xFF", 2'b10, 8'hFF, 8'hFF);
      apply("R5 or flags 0x80|0x80", 2'b11, 8'h80, 8'h80);
      check("R5 explicit or", {cy, ov}, 2'b00);
   endtask

   task automatic t_ovf();
      apply("R6 add ovf 0x7F+0x01", 2'b00, 8'h7F, 8'h01);
      check("R6 explicit", {cy, ov, res}, 10'h180);
      apply("R6 add no ovf mixed", 2'b00, 8'h7F, 8'h81);
      apply("R7 sub ovf 0x80-0x01", 2'b01, 8'h80, 8'h01);
      check("R7 explicit", {cy, ov, res}, 10'h17F);
      apply("R7 sub ovf 0x7F-0xFF", 2'b01, 8'h7F, 8'hFF);
      apply("R7 sub no ovf", 2'b01, 8'h01, 8'h02);
   endtask

   task automatic t_latency();
      logic [9:0] prev;
      apply("R8 setup", 2'b11, 8'h0F, 8'hF0);
      prev = {cy, ov, res};
      @(negedge clk);
      op = 2'b00; a = 8'h01; b = 8'h01;
      #2;
      check("R8 hold before edge", {cy, ov, res}, prev);
      @(negedge clk);
      check("R8 update after edge", {cy, ov, res}, model(2'b00, 8'h01, 8'h01));
   endtask

   task automatic t_sweep();
      for (int i = 0; i < 64; i++) begin
         logic [7:0] x, y;
         x = 8'(i * 37 + 5);
         y = 8'(i * 91 + 200);
         apply("R1 R2 R3 R4 sweep", 2'(i), x, y);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_add();
      t_sub();
      t_logic();
      t_ovf();
      t_latency();
      t_sweep();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule